// File: doc/BRIEF.md
# Performance Counter Control and Overflow Interrupt Register File

This block holds the control and status state for a bank of event counters plus one free-running cycle counter. It stores the counter values themselves. It keeps a control word with a global enable, two long-counter mode flags and a field giving how many event counters are active. It also keeps three per-counter masks: count enable, interrupt enable and overflow status. Each mask has a set view and a clear view. From the three masks and the global enable it drives a registered, level-sensitive overflow interrupt.

Software reaches every register through one read/write port. Reads are combinational. Writes take effect on the clock edge. The counting logic raises per-counter overflow pulses on a separate input. Two bits of the control word are one-shot commands: one clears the cycle counter and the other clears the active event counters. The block shows each command to the counting logic as a strobe in the cycle of the write, and never stores either bit. The active-counter field sets which mask bits exist: the low N slots plus slot 31, which is the cycle counter.

Top module: `perfctr_ctl`

## Requirements
- R1: `irq` is a registered copy of (control bit 0 AND any bit set in overflow & count-enable & interrupt-enable). It follows a change of that state one clock later. It is low whenever the global enable was low in the cycle before.
- R2: A write to a set address (count enable 0x01, interrupt enable 0x03, overflow 0x05) ORs the written ones into the mask. A write to the paired clear address (0x02, 0x04, 0x06) removes the written ones. Both addresses of a pair read back the same 32-bit value, zero-extended.
- R3: The valid mask at read-only address 0x07 has bits 0..N-1 set and bit 31 set, where N is the stored count field. With N = 0 only bit 31 is set. Mask writes to bits outside the valid mask are ignored, and writes to 0x07 have no effect.
- R4: The control word sits at address 0x00. Bit 0 is the global enable, bit 3 is long-cycle and bit 4 is long-event, and bits 12:8 hold N. A written N above NUM_EVT is stored as NUM_EVT. After reset the word is 0 with N = NUM_EVT.
- R5: Control bits 1 (event-clear command) and 2 (cycle-clear command) always read as 0. Bit 4 is stored as 0 when HAS_LONG is 0.
- R6: A control write with bit 2 set zeroes the cycle counter (address 0x3F) and raises `cycClr` during that write cycle. Event counters are left unchanged.
- R7: A control write with bit 1 set zeroes the event counters with index below the newly written N and raises those bits of `evtClr` during that write cycle. The cycle counter and event counters at or above N are left unchanged.
- R8: Event counter i sits at address 0x20+i for i < NUM_EVT. A write with `narrow` high replaces only its low CTR_W/2 bits and keeps the upper half. A write with `narrow` high to the cycle counter replaces the whole value.
- R9: Each valid bit of `ovfIn` sets the matching overflow bit. Invalid bits are ignored. A pulse on `ovfIn` wins over a clear write to the same bit in the same cycle.
- R10: After reset the masks, counters and `irq` are all 0.
- R11: Addresses not listed above read as 0 and ignore writes. This includes event counter addresses at or above NUM_EVT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Write strobe for `addr` |
| addr | input | 6 | Register address, shared by reads and writes |
| wrData | input | CTR_W | Write data; the masks and the control word use the low 32 bits |
| narrow | input | 1 | Half-width write to an event counter |
| rdData | output | CTR_W | Combinational read data for `addr` |
| ovfIn | input | 32 | Per-slot overflow pulses from the counting logic |
| cycClr | output | 1 | Cycle counter clear strobe |
| evtClr | output | NUM_EVT | Event counter clear strobes |
| irq | output | 1 | Level overflow interrupt |

## Verification
The bench builds the block with NUM_EVT = 4, HAS_LONG = 0 and CTR_W = 64. Four event slots let the tests write an N above the limit and see it clamped. They also let the tests drop N to 2 and to 0, and address a counter slot past the end. With HAS_LONG at 0 the long-event bit can be seen being forced to zero. The 64-bit width makes the kept upper half of a narrow write visible in a read.

// File: rtl/perfctr_pkg.sv
package perfctr_pkg;
  localparam int unsigned SLOTS    = 32;
  localparam int unsigned ADDR_W   = 6;
  localparam int unsigned N_W      = 5;

  localparam logic [ADDR_W-1:0] A_CTRL   = 6'h00;
  localparam logic [ADDR_W-1:0] A_EN_SET = 6'h01;
  localparam logic [ADDR_W-1:0] A_EN_CLR = 6'h02;
  localparam logic [ADDR_W-1:0] A_IE_SET = 6'h03;
  localparam logic [ADDR_W-1:0] A_IE_CLR = 6'h04;
  localparam logic [ADDR_W-1:0] A_OV_SET = 6'h05;
  localparam logic [ADDR_W-1:0] A_OV_CLR = 6'h06;
  localparam logic [ADDR_W-1:0] A_VALID  = 6'h07;
  localparam logic [ADDR_W-1:0] A_EVT0   = 6'h20;
  localparam logic [ADDR_W-1:0] A_CYC    = 6'h3F;

  localparam int unsigned B_EN      = 0;
  localparam int unsigned B_EVT_CMD = 1;
  localparam int unsigned B_CYC_CMD = 2;
  localparam int unsigned B_LCYC    = 3;
  localparam int unsigned B_LEVT    = 4;
  localparam int unsigned N_LSB     = 8;

  typedef struct packed {
    logic           enSet;
    logic           enClr;
    logic           ieSet;
    logic           ieClr;
    logic           ovSet;
    logic           ovClr;
    logic           evtWr;
    logic [N_W-1:0] evtIdx;
    logic           cycWr;
    logic           narrow;
    logic           cycClr;
    logic           evtClr;
  } strobe_t;
endpackage

// File: rtl/perfctr_dec.sv
module perfctr_dec
  import perfctr_pkg::*;
#(
  parameter int unsigned NUM_EVT  = 6,
  parameter bit          HAS_LONG = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wrWord,
  input  logic              narrow,
  output strobe_t           stb,
  output logic [31:0]       ctrlQ,
  output logic [31:0]       validMask,
  output logic [NUM_EVT-1:0] clrMask
);
  localparam logic [N_W-1:0] N_MAX = N_W'(NUM_EVT);

  function automatic logic [31:0] validOf(input logic [N_W-1:0] n);
    logic [31:0] v;
    for (int i = 0; i < 31; i++) v[i] = (N_W'(i) < n);
    v[31] = 1'b1;
    return v;
  endfunction

  function automatic logic [31:0] packCtrl(input logic en, input logic lc,
                                           input logic le, input logic [N_W-1:0] n);
    logic [31:0] c;
    c = '0;
    c[B_EN] = en;
    c[B_LCYC] = lc;
    c[B_LEVT] = le;
    c[N_LSB +: N_W] = n;
    return c;
  endfunction

  logic [N_W-1:0] wrN, newN;
  logic [31:0]    ctrlNext, newValid;
  logic           ctrlWr;

  assign wrN      = wrWord[N_LSB +: N_W];
  assign newN     = (wrN > N_MAX) ? N_MAX : wrN;
  assign ctrlNext = packCtrl(wrWord[B_EN], wrWord[B_LCYC],
                             HAS_LONG ? wrWord[B_LEVT] : 1'b0, newN);
  assign ctrlWr   = wrEn && (addr == A_CTRL);
  assign newValid = validOf(newN);
  assign clrMask  = newValid[NUM_EVT-1:0];
  assign validMask = validOf(ctrlQ[N_LSB +: N_W]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ctrlQ <= packCtrl(1'b0, 1'b0, 1'b0, N_MAX);
    else if (ctrlWr) ctrlQ <= ctrlNext;
  end

  always_comb begin
    stb        = '0;
    stb.enSet  = wrEn && (addr == A_EN_SET);
    stb.enClr  = wrEn && (addr == A_EN_CLR);
    stb.ieSet  = wrEn && (addr == A_IE_SET);
    stb.ieClr  = wrEn && (addr == A_IE_CLR);
    stb.ovSet  = wrEn && (addr == A_OV_SET);
    stb.ovClr  = wrEn && (addr == A_OV_CLR);
    stb.evtIdx = addr[N_W-1:0];
    stb.evtWr  = wrEn && addr[ADDR_W-1] && (addr[N_W-1:0] < N_MAX);
    stb.cycWr  = wrEn && (addr == A_CYC);
    stb.narrow = narrow;
    stb.cycClr = ctrlWr && wrWord[B_CYC_CMD];
    stb.evtClr = ctrlWr && wrWord[B_EVT_CMD];
  end
endmodule

// File: rtl/perfctr_dp.sv
module perfctr_dp
  import perfctr_pkg::*;
#(
  parameter int unsigned NUM_EVT = 6,
  parameter int unsigned CTR_W   = 64
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            stb,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [CTR_W-1:0]   wrData,
  input  logic [31:0]        ctrlQ,
  input  logic [31:0]        validMask,
  input  logic [NUM_EVT-1:0] clrMask,
  input  logic [31:0]        ovfIn,
  output logic [CTR_W-1:0]   rdData,
  output logic               cycClr,
  output logic [NUM_EVT-1:0] evtClr,
  output logic               irq
);
  localparam int unsigned HALF = CTR_W / 2;

  logic [31:0]      enQ, ieQ, ovQ, wMask;
  logic [CTR_W-1:0] cycCnt;
  logic [CTR_W-1:0] evtCnt [NUM_EVT];

  assign wMask  = wrData[31:0] & validMask;
  assign cycClr = stb.cycClr;
  assign evtClr = stb.evtClr ? clrMask : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enQ <= '0;
      ieQ <= '0;
      ovQ <= '0;
      irq <= 1'b0;
    end else begin
      if (stb.enSet)      enQ <= enQ | wMask;
      else if (stb.enClr) enQ <= enQ & ~wMask;
      if (stb.ieSet)      ieQ <= ieQ | wMask;
      else if (stb.ieClr) ieQ <= ieQ & ~wMask;
      ovQ <= ((ovQ | (stb.ovSet ? wMask : '0)) & ~(stb.ovClr ? wMask : '0))
             | (ovfIn & validMask);
      irq <= ctrlQ[B_EN] && (|(ovQ & enQ & ieQ));
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           cycCnt <= '0;
    else if (stb.cycClr) cycCnt <= '0;
    else if (stb.cycWr)  cycCnt <= wrData;
  end

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_evt
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        evtCnt[i] <= '0;
      else if (stb.evtClr && clrMask[i])
        evtCnt[i] <= '0;
      else if (stb.evtWr && (stb.evtIdx == N_W'(i)))
        evtCnt[i] <= stb.narrow ? {evtCnt[i][CTR_W-1:HALF], wrData[HALF-1:0]} : wrData;
    end
  end

  always_comb begin
    rdData = '0;
    case (addr)
      A_CTRL:             rdData = CTR_W'(ctrlQ);
      A_EN_SET, A_EN_CLR: rdData = CTR_W'(enQ);
      A_IE_SET, A_IE_CLR: rdData = CTR_W'(ieQ);
      A_OV_SET, A_OV_CLR: rdData = CTR_W'(ovQ);
      A_VALID:            rdData = CTR_W'(validMask);
      A_CYC:              rdData = cycCnt;
      default: begin
        for (int i = 0; i < NUM_EVT; i++)
          if (addr == ADDR_W'(A_EVT0 + i)) rdData = evtCnt[i];
      end
    endcase
  end
endmodule

// File: rtl/perfctr_ctl.sv
module perfctr_ctl
  import perfctr_pkg::*;
#(
  parameter int unsigned NUM_EVT  = 6,
  parameter bit          HAS_LONG = 1'b1,
  parameter int unsigned CTR_W    = 64
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [5:0]         addr,
  input  logic [CTR_W-1:0]   wrData,
  input  logic               narrow,
  output logic [CTR_W-1:0]   rdData,
  input  logic [31:0]        ovfIn,
  output logic               cycClr,
  output logic [NUM_EVT-1:0] evtClr,
  output logic               irq
);
  strobe_t            stb;
  logic [31:0]        ctrlQ, validMask;
  logic [NUM_EVT-1:0] clrMask;

  perfctr_dec #(.NUM_EVT(NUM_EVT), .HAS_LONG(HAS_LONG)) i_ctl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrWord(wrData[31:0]),
    .narrow(narrow), .stb(stb), .ctrlQ(ctrlQ), .validMask(validMask),
    .clrMask(clrMask)
  );

  perfctr_dp #(.NUM_EVT(NUM_EVT), .CTR_W(CTR_W)) i_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .addr(addr), .wrData(wrData),
    .ctrlQ(ctrlQ), .validMask(validMask), .clrMask(clrMask), .ovfIn(ovfIn),
    .rdData(rdData), .cycClr(cycClr), .evtClr(evtClr), .irq(irq)
  );
endmodule

// File: rtl/perfctr_chk.sv
module perfctr_chk #(
  parameter int unsigned CTR_W = 64
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic [5:0]       addr,
  input logic [CTR_W-1:0] rdData,
  input logic             irq,
  input logic             cycClr,
  input logic             evtClr0,
  input logic             glbEn,
  input logic [CTR_W-1:0] cycCnt,
  input logic [CTR_W-1:0] evtCnt0
);
  a_r1_irq_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    !glbEn |=> !irq);

  a_r5_cmd_bits_read_zero: assert property (@(posedge clk) disable iff (!rstN)
    (addr == 6'h00) |-> (rdData[2:1] == 2'b00));

  a_r3_valid_has_cycle_slot: assert property (@(posedge clk) disable iff (!rstN)
    (addr == 6'h07) |-> rdData[31]);

  a_r6_cycle_cleared: assert property (@(posedge clk) disable iff (!rstN)
    cycClr |=> (cycCnt == '0));

  a_r7_event_cleared: assert property (@(posedge clk) disable iff (!rstN)
    evtClr0 |=> (evtCnt0 == '0));

  a_r7_strobe_from_write: assert property (@(posedge clk) disable iff (!rstN)
    (evtClr0 || cycClr) |-> wrEn);
endmodule

bind perfctr_ctl perfctr_chk #(.CTR_W(CTR_W)) i_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .rdData(rdData),
  .irq(irq), .cycClr(cycClr), .evtClr0(evtClr[0]), .glbEn(i_ctl.ctrlQ[0]),
  .cycCnt(i_dp.cycCnt), .evtCnt0(i_dp.evtCnt[0])
);

// File: tb/test_perfctr_ctl.sv
module test_perfctr_ctl;
  localparam int unsigned NUM_EVT = 4;
  localparam int unsigned CTR_W   = 64;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               wrEn = 1'b0;
  logic [5:0]         addr = '0;
  logic [CTR_W-1:0]   wrData = '0;
  logic               narrow = 1'b0;
  logic [CTR_W-1:0]   rdData;
  logic [31:0]        ovfIn = '0;
  logic               cycClr;
  logic [NUM_EVT-1:0] evtClr;
  logic               irq;

  int nChk = 0;
  int nBad = 0;
  logic               seenCyc;
  logic [NUM_EVT-1:0] seenEvt;

  always #10 clk = ~clk;

  perfctr_ctl #(.NUM_EVT(NUM_EVT), .HAS_LONG(1'b0), .CTR_W(CTR_W)) i_perfctr_ctl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .narrow(narrow), .rdData(rdData), .ovfIn(ovfIn), .cycClr(cycClr),
    .evtClr(evtClr), .irq(irq)
  );

  typedef struct packed {
    logic [5:0]  wa;
    logic [31:0] wd;
    logic [5:0]  ra;
    logic [31:0] ex;
    logic        irqEx;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{6'h01, 32'h8000_00F3, 6'h02, 32'h8000_0003, 1'b0}, // R2 R3
    '{6'h03, 32'h0000_0001, 6'h04, 32'h0000_0001, 1'b0}, // R2
    '{6'h05, 32'h0000_0001, 6'h06, 32'h0000_0001, 1'b0}, // R2 R1 enable off
    '{6'h00, 32'h0000_0401, 6'h00, 32'h0000_0401, 1'b1}, // R4 R1
    '{6'h04, 32'h0000_0001, 6'h03, 32'h0000_0000, 1'b0}, // R2 R1
    '{6'h03, 32'h8000_0000, 6'h03, 32'h8000_0000, 1'b0}, // R2
    '{6'h05, 32'h8000_0000, 6'h05, 32'h8000_0001, 1'b1}, // R2 R1
    '{6'h06, 32'h8000_0001, 6'h05, 32'h0000_0000, 1'b0}, // R2 R1
    '{6'h02, 32'hFFFF_FFFF, 6'h01, 32'h0000_0000, 1'b0}, // R2
    '{6'h00, 32'h0000_091F, 6'h00, 32'h0000_0409, 1'b0}, // R4 R5
    '{6'h07, 32'h0000_0000, 6'h07, 32'h8000_000F, 1'b0}, // R3
    '{6'h00, 32'h0000_0001, 6'h07, 32'h8000_0000, 1'b0}, // R3
    '{6'h01, 32'h0000_000F, 6'h01, 32'h0000_0000, 1'b0}, // R3
    '{6'h00, 32'h0000_0401, 6'h07, 32'h8000_000F, 1'b0}  // R3
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [63:0] d, input logic nar);
    @(negedge clk);
    addr = a; wrData = d; narrow = nar; wrEn = 1'b1;
    #3;
    seenCyc = cycClr;
    seenEvt = evtClr;
    @(negedge clk);
    wrEn = 1'b0; narrow = 1'b0;
  endtask

  task automatic rdChk(input string req, input logic [5:0] a, input logic [63:0] exp);
    addr = a;
    #1;
    check(req, rdData, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10 R4 reset state
    rdChk("R4 reset ctrl", 6'h00, 64'h400);
    rdChk("R3 reset valid", 6'h07, 64'h8000_000F);
    rdChk("R10 reset enable", 6'h01, 64'h0);
    rdChk("R10 reset overflow", 6'h05, 64'h0);
    rdChk("R10 reset counter", 6'h20, 64'h0);
    check("R10 reset irq", {63'b0, irq}, 64'h0);

    for (int i = 0; i < NV; i++) begin
      wr(VECS[i].wa, {32'b0, VECS[i].wd}, 1'b0);
      rdChk($sformatf("R2/R3/R4 vector %0d read", i), VECS[i].ra, {32'b0, VECS[i].ex});
      @(negedge clk);
      check($sformatf("R1 vector %0d irq", i), {63'b0, irq}, {63'b0, VECS[i].irqEx});
    end

    // R8 narrow writes
    wr(6'h20, 64'h1111_2222_3333_4444, 1'b0);
    rdChk("R8 wide write", 6'h20, 64'h1111_2222_3333_4444);
    wr(6'h20, 64'hAAAA_BBBB_CCCC_DDDD, 1'b1);
    rdChk("R8 narrow keeps upper", 6'h20, 64'h1111_2222_CCCC_DDDD);
    wr(6'h3F, 64'h5555_6666_7777_8888, 1'b1);
    rdChk("R8 cycle narrow full", 6'h3F, 64'h5555_6666_7777_8888);

    // R11 unmapped
    wr(6'h25, 64'h1234, 1'b0);
    rdChk("R11 slot past end", 6'h25, 64'h0);
    rdChk("R11 hole", 6'h08, 64'h0);

    // R7 event clear, all active
    wr(6'h21, 64'h99, 1'b0);
    wr(6'h23, 64'h77, 1'b0);
    wr(6'h00, 64'h403, 1'b0);
    check("R7 evtClr strobe", {60'b0, seenEvt}, 64'hF);
    check("R7 cycClr quiet", {63'b0, seenCyc}, 64'h0);
    rdChk("R7 cnt0 cleared", 6'h20, 64'h0);
    rdChk("R7 cnt3 cleared", 6'h23, 64'h0);
    rdChk("R7 cycle kept", 6'h3F, 64'h5555_6666_7777_8888);
    rdChk("R5 cmd not stored", 6'h00, 64'h401);

    // R6 cycle clear
    wr(6'h22, 64'h42, 1'b0);
    wr(6'h00, 64'h405, 1'b0);
    check("R6 cycClr strobe", {63'b0, seenCyc}, 64'h1);
    check("R6 evtClr quiet", {60'b0, seenEvt}, 64'h0);
    rdChk("R6 cycle cleared", 6'h3F, 64'h0);
    rdChk("R6 event kept", 6'h22, 64'h42);

    // R7 event clear with N=2
    wr(6'h20, 64'h5, 1'b0);
    wr(6'h23, 64'h6, 1'b0);
    wr(6'h00, 64'h203, 1'b0);
    check("R7 evtClr N=2", {60'b0, seenEvt}, 64'h3);
    rdChk("R7 low cleared", 6'h20, 64'h0);
    rdChk("R7 high kept", 6'h23, 64'h6);
    wr(6'h00, 64'h401, 1'b0);

    // R9 overflow input
    wr(6'h01, 64'h4, 1'b0);
    wr(6'h03, 64'h4, 1'b0);
    @(negedge clk); ovfIn = 32'h24;
    @(negedge clk); ovfIn = 32'h0;
    rdChk("R9 ovfIn valid bits only", 6'h05, 64'h4);
    @(negedge clk);
    check("R1 irq from ovfIn", {63'b0, irq}, 64'h1);
    wr(6'h06, 64'h4, 1'b0);
    @(negedge clk);
    check("R1 irq drops on clear", {63'b0, irq}, 64'h0);
    @(negedge clk);
    addr = 6'h06; wrData = 64'h4; wrEn = 1'b1; ovfIn = 32'h4;
    @(negedge clk);
    wrEn = 1'b0; ovfIn = 32'h0;
    rdChk("R9 ovfIn beats clear", 6'h05, 64'h4);
    @(negedge clk);
    check("R1 irq high again", {63'b0, irq}, 64'h1);
    wr(6'h00, 64'h400, 1'b0);
    @(negedge clk);
    check("R1 irq off with global enable low", {63'b0, irq}, 64'h0);

    $display("  test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end
endmodule